// File: doc/BRIEF.md
# Chained 64-bit lifetime timer with coherent snapshot

The block holds two 32-bit down-counters that are linked into one 64-bit lifetime count. The low counter runs on every enabled clock. The high counter moves by one only in the cycle in which the low counter sits at zero and reloads. Each counter reloads from its own load-value register. A single input enables or pauses both counters.

Software reads the count over a simple register bus. A read of the high lifetime word returns the high counter. In the same clock, that read copies the low counter into a shadow register. A later read of the low lifetime word returns the shadow. The two words therefore describe one instant, even when the low counter wraps between the two bus accesses, and software needs no retry loop.

Top module: `lifetimer_snap`

## Requirements
- R1: After reset, both counters, both load registers, the shadow and `rdata` are zero, so every register offset reads zero.
- R2: When `en` is high, the low counter decrements by one each clock. In a cycle where it holds zero, it instead loads the low load value (offset 0x100) at that clock edge.
- R3: The high counter changes only in an enabled cycle in which the low counter holds zero. In that cycle it decrements by one, or loads the high load value (offset 0x110) if it is zero itself.
- R4: While `en` is low, neither counter changes.
- R5: A read of offset 0xE0 puts the high counter's value from the read cycle on `rdata` one clock later.
- R6: The same read of 0xE0 copies the low counter's value from that cycle into the shadow. A read of offset 0xE4 returns the shadow one clock later.
- R7: The shadow changes only on a read of 0xE0. Reads of 0xE4 and the passage of time leave it unchanged.
- R8: A write to a load register does not change the running count. The new value is used at that counter's next reload.
- R9: Writes to 0xE0 and 0xE4 are ignored. They change neither the counters nor the shadow.
- R10: The load registers read back their written value at 0x100 and 0x110. A read of any other offset returns zero.
- R11: A read of 0xE0 issued in the very cycle in which the low counter is zero and reloading still gives a coherent pair: the high counter before its step, and a low word of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable for both counters |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid one clock after `rd_en` |

## Verification
Read data is registered, so every read result is sampled at the falling edge one clock after the read was driven. The expected high word is the reference counter value held during the read cycle. The expected low word is the reference low counter value latched in that same cycle. A counter step or a shadow capture becomes visible at the edge that ends its cycle, and the bench models both against its own copy of the load values. Reads are placed deliberately on the wrap cycle and right after a load write, so that the one-cycle timing of reload and capture is checked at its boundary.

// File: rtl/lts_pkg.sv
package lts_pkg;
  localparam int ADDR_W    = 12;
  localparam int NUM_TMR   = 2;
  localparam logic [ADDR_W-1:0] OFF_HI   = 12'h0E0;
  localparam logic [ADDR_W-1:0] OFF_LO   = 12'h0E4;
  localparam logic [ADDR_W-1:0] OFF_LD0  = 12'h100;
  localparam logic [ADDR_W-1:0] OFF_LD1  = 12'h110;
endpackage

// File: rtl/lts_down_counter.sv
module lts_down_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         at_zero
);
  assign at_zero = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (step) begin
      if (at_zero) count <= load_val;
      else         count <= count - W'(1);
    end
  end
endmodule

// File: rtl/lts_regs.sv
module lts_regs
  import lts_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cnt_lo,
  input  logic [DATA_W-1:0] cnt_hi,
  output logic [DATA_W-1:0] ld0,
  output logic [DATA_W-1:0] ld1,
  output logic [DATA_W-1:0] shadow,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rd_mux;

  // load registers; the lifetime words are read-only
  always_ff @(posedge clk) begin
    if (rst) begin
      ld0 <= '0;
      ld1 <= '0;
    end else if (wr_en) begin
      if (addr == OFF_LD0) ld0 <= wdata;
      if (addr == OFF_LD1) ld1 <= wdata;
    end
  end

  // snapshot of the low counter, taken only by a high-word read
  always_ff @(posedge clk) begin
    if (rst)                          shadow <= '0;
    else if (rd_en && addr == OFF_HI) shadow <= cnt_lo;
  end

  always_comb begin
    case (addr)
      OFF_HI:  rd_mux = cnt_hi;
      OFF_LO:  rd_mux = shadow;
      OFF_LD0: rd_mux = ld0;
      OFF_LD1: rd_mux = ld1;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/lifetimer_snap.sv
module lifetimer_snap
  import lts_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [NUM_TMR-1:0] step;
  logic [NUM_TMR-1:0] zero;
  logic [DATA_W-1:0]  cnt [NUM_TMR];
  logic [DATA_W-1:0]  ld  [NUM_TMR];
  logic [DATA_W-1:0]  cnt_lo, cnt_hi, shadow;

  // each stage steps when every stage below it is at zero and reloading
  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    if (g == 0) begin : g_base
      assign step[g] = en;
    end else begin : g_chain
      assign step[g] = en & (&zero[g-1:0]);
    end
    lts_down_counter #(.W(DATA_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .step     (step[g]),
      .load_val (ld[g]),
      .count    (cnt[g]),
      .at_zero  (zero[g])
    );
  end

  assign cnt_lo = cnt[0];
  assign cnt_hi = cnt[1];

  lts_regs #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .cnt_lo (cnt_lo),
    .cnt_hi (cnt_hi),
    .ld0    (ld[0]),
    .ld1    (ld[1]),
    .shadow (shadow),
    .rdata  (rdata)
  );
endmodule

// File: rtl/lts_checker.sv
module lts_checker
  import lts_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] cnt0,
  input logic [DATA_W-1:0] cnt1,
  input logic [DATA_W-1:0] shadow
);
  p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(cnt0) && $stable(cnt1)));

  p_lo_step_r2: assert property (@(posedge clk) disable iff (rst)
    (en && cnt0 != '0) |=> (cnt0 == $past(cnt0) - DATA_W'(1)));

  p_hi_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (en && cnt0 != '0) |=> $stable(cnt1));

  p_hi_read_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFF_HI) |=> (rdata == $past(cnt1)));

  p_capture_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFF_HI) |=> (shadow == $past(cnt0)));

  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && addr == OFF_HI) |=> $stable(shadow));
endmodule

bind lifetimer_snap lts_checker #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .en     (en),
  .rd_en  (rd_en),
  .addr   (addr),
  .rdata  (rdata),
  .cnt0   (cnt_lo),
  .cnt1   (cnt_hi),
  .shadow (shadow)
);

// File: tb/lifetimer_snap_bench.sv
module lifetimer_snap_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model built from R2, R3, R8
  logic [31:0] r0, r1, bl0, bl1, rsh;

  always #5 clk = ~clk;

  lifetimer_snap u_lifetimer_snap (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always @(posedge clk) begin
    if (rst) begin
      r0 <= '0; r1 <= '0; bl0 <= '0; bl1 <= '0;
    end else begin
      if (en) begin
        if (r0 == 0) begin
          r0 <= bl0;
          r1 <= (r1 == 0) ? bl1 : r1 - 1;
        end else begin
          r0 <= r0 - 1;
        end
      end
      if (wr_en && addr == 12'h100) bl0 <= wdata;
      if (wr_en && addr == 12'h110) bl1 <= wdata;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the data is valid
  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // high read then low read, both compared with the model state of the high-read cycle
  task automatic pair_check(string tag);
    logic [31:0] e_hi, e_lo, d;
    e_hi = r1; e_lo = r0;
    bus_rd(12'h0E0, d);
    chk({tag, " high word"}, d, e_hi);
    rsh = e_lo;
    bus_rd(12'h0E4, d);
    chk({tag, " low word"}, d, e_lo);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_rd(12'h0E0, d); chk("R1 high after reset", d, 0);
    bus_rd(12'h0E4, d); chk("R1 low after reset", d, 0);
    bus_rd(12'h100, d); chk("R1 load0 after reset", d, 0);
  endtask

  task automatic t_loads;
    logic [31:0] d;
    bus_wr(12'h100, 32'd5);
    bus_wr(12'h110, 32'd3);
    bus_rd(12'h100, d); chk("R10 load0 readback", d, 32'd5);
    bus_rd(12'h110, d); chk("R10 load1 readback", d, 32'd3);
  endtask

  task automatic t_count;
    en = 1'b1;
    repeat (4) @(negedge clk);
    pair_check("R2 R3 R5 R6 early count");
    repeat (23) @(negedge clk);
    pair_check("R2 R3 R5 R6 later count");
  endtask

  task automatic t_freeze;
    logic [31:0] a, b;
    en = 1'b0;
    @(negedge clk);
    bus_rd(12'h0E0, a);
    repeat (10) @(negedge clk);
    bus_rd(12'h0E0, b);
    chk("R4 high frozen", b, a);
    pair_check("R4 frozen pair");
    en = 1'b1;
  endtask

  task automatic t_shadow_hold;
    logic [31:0] d;
    pair_check("R6 capture");
    repeat (7) @(negedge clk);
    bus_rd(12'h0E4, d); chk("R7 low held first", d, rsh);
    repeat (5) @(negedge clk);
    bus_rd(12'h0E4, d); chk("R7 low held second", d, rsh);
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 3; i++) begin
      while (r0 != 0) @(negedge clk);
      pair_check("R11 read on wrap cycle");
    end
    while (r0 != 1) @(negedge clk);
    pair_check("R11 read one before wrap");
  endtask

  task automatic t_ignore;
    logic [31:0] d;
    pair_check("R9 prior capture");
    bus_wr(12'h0E0, 32'hFFFF_FFFF);
    bus_wr(12'h0E4, 32'hFFFF_FFFF);
    bus_rd(12'h0E4, d); chk("R9 low unchanged by writes", d, rsh);
    pair_check("R9 counters unchanged by writes");
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    bus_rd(12'h004, d); chk("R10 unmapped 0x004", d, 0);
    bus_rd(12'h200, d); chk("R10 unmapped 0x200", d, 0);
  endtask

  task automatic t_reload_write;
    logic [31:0] d;
    while (r0 != 3) @(negedge clk);
    bus_wr(12'h100, 32'd9);
    bus_rd(12'h0E0, d);
    bus_rd(12'h0E4, d); chk("R8 old count continues", d, 32'd2);
    while (r0 != 0) @(negedge clk);
    @(negedge clk);
    bus_rd(12'h0E0, d);
    bus_rd(12'h0E4, d); chk("R8 new load used at reload", d, 32'd9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_loads();
    t_count();
    t_freeze();
    t_shadow_hold();
    t_wrap();
    t_ignore();
    t_unmapped();
    t_reload_write();
    t_wrap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule